// File: doc/BRIEF.md
# GGA Position Field Extractor

This block sits behind a UART receiver and watches a stream of ASCII bytes, each qualified by a valid strobe. Every `$` begins a new sentence. The two talker characters that follow are skipped, and the next three characters are compared against the `GGA` type code. Any other sentence type is dropped. The parser then ignores everything until the next `$`.

Inside a matching sentence the block counts commas to find the latitude field and the longitude field. It forwards each of their characters as it arrives. There is no sentence buffer, so downstream logic sees the position digits one cycle after they come off the wire. Each forwarded character carries a one-cycle strobe and a tag that names its field. A separate one-cycle flag marks the comma that closes each of the two fields.

A `*`, carriage return or line feed ends the sentence and returns the parser to waiting for `$`. Time, hemisphere and all later fields are never forwarded.

Top module: `gga_pos_extract`

## Requirements
- R1: After reset `chr_valid_o`, `fld_end_o`, `chr_tag_o` and `chr_o` are all zero.
- R2: In a sentence of type `GGA`, every character of the field after the second comma, other than `*`, CR (0x0D), LF (0x0A) and `$`, appears on `chr_o` with `chr_valid_o` high and `chr_tag_o` = 0. This happens for exactly one cycle, in the cycle after the byte is accepted.
- R3: Characters of the field after the fourth comma are forwarded the same way with `chr_tag_o` = 1.
- R4: The comma that closes the latitude field (third comma) or the longitude field (fifth comma) raises `fld_end_o` for one cycle, with the matching tag. `chr_valid_o` stays low in that cycle.
- R5: A sentence whose three type characters differ from `GGA` in any position produces no output up to the next `$`.
- R6: Bytes received before any `$` produce no output. Any two characters are accepted as talker ID, and gaps in `rx_valid_i` do not change the result.
- R7: A `$` in any state restarts parsing of a new sentence. Output from the interrupted sentence stops at that `$`.
- R8: A `*`, CR or LF ends the sentence. Later bytes produce no output until the next `$`, and the terminator itself produces no output.
- R9: An empty latitude or longitude field (two adjacent commas) produces only the `fld_end_o` pulse, with no character strobe.
- R10: Characters of the time field, the two hemisphere fields and every field after the longitude are never forwarded.
- R11: `chr_valid_o` and `fld_end_o` are never high together, and either one is high only in the cycle after a byte was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received ASCII byte |
| rx_valid_i | input | 1 | Byte strobe, one cycle per byte |
| chr_o | output | 8 | Forwarded position character |
| chr_valid_o | output | 1 | One-cycle strobe for `chr_o` |
| chr_tag_o | output | 1 | Field tag: 0 latitude, 1 longitude |
| fld_end_o | output | 1 | One-cycle flag on the comma closing a tagged field |

## Verification
The bench feeds complete sentences and compares the ordered list of tagged events against a list built from the sentence text. A full GGA sentence shows that only the two position fields pass and that each has the correct tag. Sentences of another type, and sentences with a type code that differs in one character or is truncated, show that type filtering holds. Further sentences test sequences cut short by `$`, by `*`, by CR and by LF, empty position fields, noise before the first `$` under a gapped valid strobe, and extra fields after the longitude. Each of these separates restart, abort and field-count behaviour. One directed byte-by-byte pass checks the single-cycle latency and that a character strobe and an end flag never share a cycle.

// File: rtl/gga_pkg.sv
package gga_pkg;
  typedef enum logic [1:0] {HS_IDLE, HS_TALK, HS_TYPE, HS_BODY} hdr_state_e;

  localparam logic [7:0] CH_START = 8'h24;  // '$'
  localparam logic [7:0] CH_SEP   = 8'h2C;  // ','
  localparam logic [7:0] CH_STAR  = 8'h2A;  // '*'
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;
endpackage

// File: rtl/gga_hdr_match.sv
module gga_hdr_match
  import gga_pkg::*;
#(
  parameter int unsigned TALK_LEN = 2,
  parameter int unsigned TYPE_LEN = 3,
  parameter logic [8*TYPE_LEN-1:0] TYPE_CODE = "GGA"
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  input  logic       is_start_i,
  input  logic       is_term_i,
  input  logic       done_i,
  output logic       in_body_o
);
  localparam int unsigned MAXLEN = (TALK_LEN > TYPE_LEN) ? TALK_LEN : TYPE_LEN;
  localparam int unsigned CW     = $clog2(MAXLEN + 1);
  localparam int unsigned NSLOT  = 2 ** CW;

  hdr_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic [7:0]     exp_chr [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_exp
    if (g < TYPE_LEN) begin : g_used
      assign exp_chr[g] = TYPE_CODE[8*(TYPE_LEN-1-g) +: 8];
    end else begin : g_unused
      assign exp_chr[g] = 8'h00;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
    end else if (valid_i) begin
      if (is_start_i) begin
        state_q <= HS_TALK;
        cnt_q   <= '0;
      end else if (is_term_i) begin
        state_q <= HS_IDLE;
      end else begin
        unique case (state_q)
          HS_IDLE: ;
          HS_TALK: begin
            if (cnt_q == CW'(TALK_LEN - 1)) begin
              state_q <= HS_TYPE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          HS_TYPE: begin
            if (data_i != exp_chr[cnt_q]) state_q <= HS_IDLE;
            else if (cnt_q == CW'(TYPE_LEN - 1)) state_q <= HS_BODY;
            else cnt_q <= cnt_q + 1'b1;
          end
          HS_BODY: if (done_i) state_q <= HS_IDLE;
          default: state_q <= HS_IDLE;
        endcase
      end
    end
  end

  assign in_body_o = (state_q == HS_BODY);
endmodule

// File: rtl/gga_field_cnt.sv
module gga_field_cnt #(
  parameter int unsigned LAT_FIELD = 2,
  parameter int unsigned LON_FIELD = 4,
  localparam int unsigned FW = $clog2(LON_FIELD + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_body_i,
  input  logic          valid_i,
  input  logic          is_sep_i,
  output logic          in_lat_o,
  output logic          in_lon_o,
  output logic          done_o
);
  logic [FW-1:0] fld_q;

  // field index = commas seen since the type code
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              fld_q <= '0;
    else if (!in_body_i)                      fld_q <= '0;
    else if (valid_i && is_sep_i && !done_o)  fld_q <= fld_q + 1'b1;
  end

  assign in_lat_o = in_body_i && (fld_q == FW'(LAT_FIELD));
  assign in_lon_o = in_body_i && (fld_q == FW'(LON_FIELD));
  assign done_o   = in_lon_o && valid_i && is_sep_i;
endmodule

// File: rtl/gga_pos_extract.sv
module gga_pos_extract
  import gga_pkg::*;
#(
  parameter int unsigned TALK_LEN  = 2,
  parameter int unsigned TYPE_LEN  = 3,
  parameter logic [8*TYPE_LEN-1:0] TYPE_CODE = "GGA",
  parameter int unsigned LAT_FIELD = 2,
  parameter int unsigned LON_FIELD = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] rx_data_i,
  input  logic       rx_valid_i,
  output logic [7:0] chr_o,
  output logic       chr_valid_o,
  output logic       chr_tag_o,
  output logic       fld_end_o
);
  logic is_start, is_term, is_sep;
  logic in_body, in_lat, in_lon, done;

  assign is_start = (rx_data_i == CH_START);
  assign is_sep   = (rx_data_i == CH_SEP);
  assign is_term  = (rx_data_i == CH_STAR) || (rx_data_i == CH_CR) || (rx_data_i == CH_LF);

  gga_hdr_match #(
    .TALK_LEN (TALK_LEN),
    .TYPE_LEN (TYPE_LEN),
    .TYPE_CODE(TYPE_CODE)
  ) u_hdr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_i    (rx_data_i),
    .valid_i   (rx_valid_i),
    .is_start_i(is_start),
    .is_term_i (is_term),
    .done_i    (done),
    .in_body_o (in_body)
  );

  gga_field_cnt #(
    .LAT_FIELD(LAT_FIELD),
    .LON_FIELD(LON_FIELD)
  ) u_fld (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_body_i(in_body),
    .valid_i  (rx_valid_i),
    .is_sep_i (is_sep),
    .in_lat_o (in_lat),
    .in_lon_o (in_lon),
    .done_o   (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chr_o       <= '0;
      chr_valid_o <= 1'b0;
      chr_tag_o   <= 1'b0;
      fld_end_o   <= 1'b0;
    end else begin
      chr_valid_o <= 1'b0;
      fld_end_o   <= 1'b0;
      if (rx_valid_i && (in_lat || in_lon) && !is_term && !is_start) begin
        chr_tag_o <= in_lon;
        if (is_sep) begin
          fld_end_o <= 1'b1;
        end else begin
          chr_valid_o <= 1'b1;
          chr_o       <= rx_data_i;
        end
      end
    end
  end
endmodule

// File: rtl/gga_pos_extract_chk.sv
module gga_pos_extract_chk
  import gga_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] rx_data_i,
  input logic       rx_valid_i,
  input logic [7:0] chr_o,
  input logic       chr_valid_o,
  input logic       chr_tag_o,
  input logic       fld_end_o
);
  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(chr_valid_o && fld_end_o));

  p_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chr_valid_o || fld_end_o) |-> $past(rx_valid_i));

  p_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_valid_o |-> (chr_o == $past(rx_data_i)));

  p_no_ctrl_chr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_valid_o |-> (chr_o != CH_START && chr_o != CH_SEP));

  p_term_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rx_valid_i) && ($past(rx_data_i) == CH_STAR || $past(rx_data_i) == CH_CR
      || $past(rx_data_i) == CH_LF)) |-> !(chr_valid_o || fld_end_o));

  p_end_on_sep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fld_end_o |-> ($past(rx_data_i) == CH_SEP));
endmodule

bind gga_pos_extract gga_pos_extract_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_data_i  (rx_data_i),
  .rx_valid_i (rx_valid_i),
  .chr_o      (chr_o),
  .chr_valid_o(chr_valid_o),
  .chr_tag_o  (chr_tag_o),
  .fld_end_o  (fld_end_o)
);

// File: tb/gga_pos_extract_tb_top.sv
`timescale 1ns/1ps
module gga_pos_extract_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] chr;
  logic       chr_valid, chr_tag, fld_end;

  int    n_chk = 0;
  int    n_err = 0;
  string ev_log = "";

  always #2.5 clk = ~clk;

  gga_pos_extract dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rx_data_i  (rx_data),
    .rx_valid_i (rx_valid),
    .chr_o      (chr),
    .chr_valid_o(chr_valid),
    .chr_tag_o  (chr_tag),
    .fld_end_o  (fld_end)
  );

  // event log: a<c>/o<c> lat/lon char, A/O lat/lon field end
  always @(negedge clk) begin
    if (rst_n) begin
      if (chr_valid) ev_log = {ev_log, $sformatf("%s%c", chr_tag ? "o" : "a", chr)};
      if (fld_end)   ev_log = {ev_log, chr_tag ? "O" : "A"};
    end
  end

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%s expected=%s", req, act, exp);
    end
  endtask

  function automatic string fx(input bit lon, input string s);
    string r = "";
    for (int i = 0; i < s.len(); i++) r = {r, $sformatf("%s%c", lon ? "o" : "a", s[i])};
    return {r, lon ? "O" : "A"};
  endfunction

  task automatic send(input string s, input bit gap);
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk);
      rx_data  = s[i];
      rx_valid = 1'b1;
      if (gap) begin
        @(negedge clk);
        rx_valid = 1'b0;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input string s, input bit gap, input string exp, input string req);
    ev_log = "";
    send(s, gap);
    chk(ev_log == exp, req, ev_log, exp);
  endtask

  task automatic t_reset;
    chk(chr_valid == 0 && fld_end == 0 && chr_tag == 0 && chr == 0, "R1",
        $sformatf("%b%b%b%02h", chr_valid, fld_end, chr_tag, chr), "00000");
  endtask

  task automatic t_full;
    // R2 R3 R4 R10: only lat/lon pass, tagged, closed by end flags
    run("$GPGGA,123519,4807.038,N,01131.000,E,1,08,0.9,545.4,M*47\r\n", 1'b0,
        {fx(0, "4807.038"), fx(1, "01131.000")}, "R2/R3/R4");
    run("$GPGGA,1,2,N,3,E,4,5,6,7\r\n", 1'b0, {fx(0, "2"), fx(1, "3")}, "R10");
  endtask

  task automatic t_other_type;
    run("$GPRMC,123519,A,4807.038,N,01131.000,E*6A\r\n", 1'b0, "", "R5 rmc");
    run("$GPGGX,1,5,N,6,E\r\n", 1'b0, "", "R5 last char");
    run("$GPGG,1,5,N,6,E\r\n", 1'b0, "", "R5 short");
  endtask

  task automatic t_noise_talker;
    run("xx,12,34,$GNGGA,1,22,N,33,W\r\n", 1'b1, {fx(0, "22"), fx(1, "33")}, "R6");
  endtask

  task automatic t_empty;
    run("$GPGGA,1,,N,,E\r\n", 1'b0, "AO", "R9");
  endtask

  task automatic t_restart;
    run("$GPGGA,1,48$GPRMC,1,99,N,77\r\n$GPGGA,1,5,N,6,E\n", 1'b0,
        {"a4a8", fx(0, "5"), fx(1, "6")}, "R7");
  endtask

  task automatic t_abort;
    run("$GPGGA,1,4*,,77,88,", 1'b0, "a4", "R8 star");
    run("$GPGGA\r,,5,,6,", 1'b0, "", "R8 cr");
    run("$GPGGA,1\n,5,,6,", 1'b0, "", "R8 lf");
  endtask

  task automatic t_latency;
    ev_log = "";
    send("$GPGGA,1,", 1'b0);
    @(negedge clk);
    rx_data = "7"; rx_valid = 1'b1;
    @(negedge clk);
    chk(chr_valid == 1 && chr == "7" && chr_tag == 0 && fld_end == 0, "R2 latency",
        $sformatf("%b%c%b%b", chr_valid, chr, chr_tag, fld_end), "17 00");
    rx_data = ","; rx_valid = 1'b1;
    @(negedge clk);
    chk(fld_end == 1 && chr_valid == 0 && chr_tag == 0, "R11 excl/R4",
        $sformatf("%b%b%b", fld_end, chr_valid, chr_tag), "100");
    rx_valid = 1'b0;
    @(negedge clk);
    chk(fld_end == 0 && chr_valid == 0, "R11 one cycle",
        $sformatf("%b%b", fld_end, chr_valid), "00");
    send("\n", 1'b0);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_other_type();
    t_noise_talker();
    t_empty();
    t_restart();
    t_abort();
    t_latency();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule